// File: doc/BRIEF.md
# Peripheral Clock-Gating Register with Wake

This block holds one 32-bit power management word that software reads and writes over a simple synchronous bus port. Twelve bits of the word each stop the clock of one peripheral: debug, Ethernet, interrupt controller, DRAM controller, DMA, PWM, QSPI, timer, parallel port, USB, UART0 and UART1. A bit at 1 stops that peripheral's clock and a bit at 0 lets it run. The block drives one registered clock-enable output per peripheral, and the clock-gating cells outside the block use these outputs.

Some clocks can come back without software. While a UART's power-down bit is set, a level change on that UART's receive line clears the bit by hardware. While the USB bit is set, a level change on the USB D+ line or on the USB wake pin clears the USB bit. The wake inputs are asynchronous, so each one passes through a two-flop synchronizer. A change is found by comparing the synchronized level with its value one cycle earlier.

Top module: `clkgate_pmr`

## Requirements
- R1: A cycle with `bus_sel` and `bus_we` both high stores the implemented bits of `bus_wdata` into the register at that clock edge. While `bus_sel` is high, `bus_rdata` shows the stored word. While `bus_sel` is low, `bus_rdata` is zero.
- R2: Only bits 31 and 26 down to 16 are implemented, so the implemented mask is 0x87FF0000. All other bits read as zero, and writing them has no effect.
- R3: After reset the register reads zero and every clock-enable output is 1.
- R4: Each `clk_en[i]` equals the inverse of its power-down bit, one clock later.
- R5: The power-down bit positions are debug 31, Ethernet 26, interrupt controller 25, DRAM 24, DMA 23, PWM 22, QSPI 21, timer 20, parallel port 19, USB 18, UART1 17 and UART0 16. `clk_en` index 0 to 11 maps to UART0, UART1, USB, parallel port, timer, QSPI, PWM, DMA, DRAM, interrupt controller, Ethernet and debug, in that order.
- R6: While bit 16 is set, a level change on `uart0_rxd` clears bit 16 at the third rising edge after the change. `clk_en[0]` rises one edge after that.
- R7: While bit 17 is set, a level change on `uart1_rxd` clears bit 17 with the same timing as R6.
- R8: While bit 18 is set, a level change on either `usb_dp` or `usb_wake` clears bit 18 with the same timing as R6.
- R9: A level change on a wake input while its power-down bit is clear has no effect, including after that bit is set again later.
- R10: If a wake clear and a bus write that sets the same bit fall on the same edge, the bit ends up clear. The other bits take the written value.
- R11: A cycle without both `bus_sel` and `bus_we` high and without a wake clear leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register selected for this cycle |
| bus_we | input | 1 | Write strobe, valid while selected |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| uart0_rxd | input | 1 | UART0 receive line, asynchronous |
| uart1_rxd | input | 1 | UART1 receive line, asynchronous |
| usb_dp | input | 1 | USB D+ line, asynchronous |
| usb_wake | input | 1 | USB wake interrupt pin, asynchronous |
| clk_en | output | 12 | Per-peripheral clock enables, index order as in R5 |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and twelve gated peripherals. With these values the full bit map, including the isolated debug bit at the top, is covered by the vector table. All four wake sources are exercised, each with its exact three-edge latency. A wake change is lined up with a bus write on the same edge to show that the wake clear takes priority. A wake change is also applied while the matching clock already runs, and the bench confirms that it leaves no trace when the bit is set again afterwards.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int NPER  = 12;
  localparam int NWAKE = 4;

  localparam int IDX_UART0 = 0;
  localparam int IDX_UART1 = 1;
  localparam int IDX_USB   = 2;

  localparam int W_UART0 = 0;
  localparam int W_UART1 = 1;
  localparam int W_USBDP = 2;
  localparam int W_USBWK = 3;

  // Register bit position of peripheral index idx.
  function automatic int bit_pos(input int idx);
    return (idx == NPER - 1) ? 31 : 16 + idx;
  endfunction

  // Word with every implemented bit set.
  function automatic logic [31:0] impl_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NPER; i++) m[bit_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] chg
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign chg = s2_q ^ prev_q;
endmodule

// File: rtl/pd_clken.sv
module pd_clken #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pd_vec,
  output logic [N-1:0] clk_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en <= '1;
    else        clk_en <= ~pd_vec;
  end

  AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en == ~$past(pd_vec)); // R4
endmodule

// File: rtl/clkgate_pmr.sv
module clkgate_pmr
  import pmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uart0_rxd,
  input  logic              uart1_rxd,
  input  logic              usb_dp,
  input  logic              usb_wake,
  output logic [NPER-1:0]   clk_en
);
  logic [NPER-1:0]  pd_q, pd_d, wr_vec, wake_clr;
  logic [NWAKE-1:0] wake_in, wake_chg;
  logic [DATA_W-1:0] rd_word;
  logic             wr_en;

  assign wr_en = bus_sel & bus_we;

  always_comb begin
    wake_in          = '0;
    wake_in[W_UART0] = uart0_rxd;
    wake_in[W_UART1] = uart1_rxd;
    wake_in[W_USBDP] = usb_dp;
    wake_in[W_USBWK] = usb_wake;
  end

  wake_sync #(.W(NWAKE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(wake_in), .chg(wake_chg)
  );

  // Wake clears exist only for the UARTs and USB; they count only while the bit is set.
  generate
    for (genvar i = 0; i < NPER; i++) begin : g_bit
      assign wr_vec[i] = bus_wdata[bit_pos(i)];
      if (i == IDX_UART0) begin : g_u0
        assign wake_clr[i] = wake_chg[W_UART0] & pd_q[i];
      end else if (i == IDX_UART1) begin : g_u1
        assign wake_clr[i] = wake_chg[W_UART1] & pd_q[i];
      end else if (i == IDX_USB) begin : g_usb
        assign wake_clr[i] = (wake_chg[W_USBDP] | wake_chg[W_USBWK]) & pd_q[i];
      end else begin : g_none
        assign wake_clr[i] = 1'b0;
      end

      AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr[i] |=> !pd_q[i]); // R10
      AST_SET_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_q[i]) |-> $past(wr_en && bus_wdata[bit_pos(i)])); // R1
    end
  endgenerate

  always_comb begin
    pd_d = wr_en ? wr_vec : pd_q;
    pd_d = pd_d & ~wake_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= '0;
    else        pd_q <= pd_d;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NPER; i++) rd_word[bit_pos(i)] = pd_q[i];
  end
  assign bus_rdata = bus_sel ? rd_word : '0;

  pd_clken #(.N(NPER)) u_en (
    .clk(clk), .rst_n(rst_n), .pd_vec(pd_q), .clk_en(clk_en)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && wake_clr == '0) |=> $stable(pd_q)); // R11
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wake_clr == '0) |=> (bus_rdata & ~impl_mask()) == '0); // R2
endmodule

// File: tb/sim_clkgate_pmr.sv
module sim_clkgate_pmr;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 1, bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        uart0_rxd = 1, uart1_rxd = 1, usb_dp = 0, usb_wake = 1;
  logic [11:0] clk_en;
  int n_chk = 0, n_bad = 0;

  localparam logic [31:0] MASK = 32'h87FF_0000;
  localparam int POS [12] = '{16, 17, 18, 19, 20, 21, 22, 23, 24, 25, 26, 31};
  localparam logic [31:0] VW [6] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000,
                                     32'h07FF_0000, 32'h7800_FFFF, 32'hA5A5_A5A5};

  always #5 clk = ~clk;

  clkgate_pmr u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uart0_rxd(uart0_rxd),
    .uart1_rxd(uart1_rxd), .usb_dp(usb_dp), .usb_wake(usb_wake), .clk_en(clk_en));

  function automatic logic [11:0] exp_en(input logic [31:0] w);
    logic [11:0] e;
    for (int i = 0; i < 12; i++) e[i] = ~w[POS[i]];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_write(input logic [31:0] w);
    bus_sel = 1; bus_we = 1; bus_wdata = w;
    cyc(1);
    bus_we = 0; bus_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(4);
    chk("R3 reset read", bus_rdata, 32'h0);
    chk("R3 reset clk_en", {20'h0, clk_en}, {20'h0, 12'hFFF});

    // R1 R2 R4 R5 vector table
    for (int v = 0; v < 6; v++) begin
      do_write(VW[v]);
      chk("R1 R2 R5 readback", bus_rdata, VW[v] & MASK);
      cyc(1);
      chk("R4 R5 clk_en", {20'h0, clk_en}, {20'h0, exp_en(VW[v])});
    end

    // R11 no write without both strobes; R1 rdata zero when unselected
    do_write(32'h8000_0000);
    bus_sel = 1; bus_we = 0; bus_wdata = '1; cyc(1);
    bus_sel = 0; bus_we = 1; cyc(1);
    chk("R1 rdata when unselected", bus_rdata, 32'h0);
    bus_sel = 1; bus_we = 0; bus_wdata = '0; #1;
    chk("R11 no stray write", bus_rdata, 32'h8000_0000);

    // R6 UART0 wake with latency
    do_write(32'h0001_0000); cyc(2);
    uart0_rxd = 0;
    cyc(2);
    chk("R6 still set after 2 edges", bus_rdata, 32'h0001_0000);
    cyc(1);
    chk("R6 cleared at 3rd edge", bus_rdata, 32'h0);
    chk("R6 clk_en0 not yet", {31'h0, clk_en[0]}, 32'h0);
    cyc(1);
    chk("R6 clk_en0 restored", {31'h0, clk_en[0]}, 32'h1);

    // R7 UART1 wake
    do_write(32'h0002_0000); cyc(2);
    uart1_rxd = 0; cyc(3);
    chk("R7 uart1 wake", bus_rdata, 32'h0);

    // R8 USB via D+ then via wake pin
    do_write(32'h0004_0000); cyc(2);
    usb_dp = 1; cyc(3);
    chk("R8 usb dp wake", bus_rdata, 32'h0);
    do_write(32'h0004_0000); cyc(2);
    usb_wake = 0; cyc(3);
    chk("R8 usb wake pin", bus_rdata, 32'h0);

    // R9 changes while clocks run are ignored
    do_write(32'h0); cyc(1);
    uart0_rxd = 1; uart1_rxd = 1; usb_dp = 0; cyc(5);
    do_write(32'h0007_0000); cyc(5);
    chk("R9 activity ignored while enabled", bus_rdata, 32'h0007_0000);
    cyc(1);
    chk("R9 clk_en stays off", {20'h0, clk_en}, {20'h0, 12'hFF8});

    // R10 wake beats same-edge write
    do_write(32'h0002_0000); cyc(2);
    uart1_rxd = 0; cyc(2);
    do_write(32'h87FF_0000);
    chk("R10 wake wins over write", bus_rdata, 32'h87FD_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule